// File: doc/BRIEF.md
# Synchronous slave serial transmitter

This block sends words over a clocked serial link where another device owns the bit clock. The remote master drives the shift clock into `sclk_i`. The block samples that clock into the system clock domain and moves one data bit onto `sdo_o` for each falling edge. Because the remote clock paces the link, shifting continues while the local core is idle. The core sees a small register port. Through it the core sets control enables, writes the holding register, enables the interrupt and reads status.

The path has two buffers. A word written to the holding register moves into the shift register as soon as the shifter is free, so a second word can wait behind the one being sent. The transmit flag is set each time a word leaves the holding register and is cleared by each new write to it. Gated by the interrupt enable, that flag forms a level request that can wake a sleeping core. A word can be 8 bits, or 9 bits with a separately programmed ninth bit.

Register map (`bus_addr_i`):
- 0 control, read/write: bit0 port enable, bit1 synchronous select, bit2 internal-clock select (must be 0), bit3 transmit enable, bit4 9-bit frame, bit5 ninth data bit, bit6 continuous-receive enable, bit7 single-receive enable.
- 1 holding register, write only (reads 0).
- 2 status, read only: bit0 shifter empty, bit1 transmit flag.
- 3 interrupt enable, read/write: bit0.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x01 (shifter empty, flag clear), interrupt enable reads 0, and both `irq_o` and `sdo_o` are 0.
- R2: Shifting is allowed only when control has port enable, synchronous select and transmit enable set, and has internal-clock select and both receive enables clear. Otherwise a written word is not sent: `sdo_o` stays 0 and status stays 0x01. The word is kept and is sent once the control becomes valid.
- R3: Data goes out least significant bit first, one bit for each falling edge of `sclk_i`. Each bit is valid on `sdo_o` before the next rising edge of `sclk_i`, and `sdo_o` changes at no other time while shifting is allowed.
- R4: When control bit4 is set, each frame has 9 bits, and its ninth bit is control bit5.
- R5: A word written while the shifter is empty enters the shifter at once and sets the flag. A second word written during shifting waits, and the flag stays clear. At the falling edge after the last bit of the first word, the second word's first bit is driven and the flag is set.
- R6: Writing the holding register clears the transmit flag on the next clock.
- R7: `irq_o` is high exactly when both the transmit flag and the interrupt enable are set.
- R8: Status bit0 is 0 while a word is shifting. It returns to 1, with `sdo_o` at 0, on the falling edge after the last bit when no word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Shift clock from the external master, idle high |
| sdo_o | output | 1 | Serial data out |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
A wrong bit counter shows up on the serial line as a frame that is too short or too long. It is seen within one frame, as a shifted word or a status bit0 that rises one falling edge early or late. A flag that is wrongly set or cleared when a word is handed over appears on status bit1 and `irq_o` within one system clock of the transfer or the write. A wrong enable gate shows up as activity on `sdo_o` at the first falling edge after a gated write.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_HOLD = 2'd1,
    A_STAT = 2'd2,
    A_IEN  = 2'd3
  } sst_addr_e;

  typedef struct packed {
    logic rx_single;
    logic rx_cont;
    logic bit9_val;
    logic frame9;
    logic tx_en;
    logic clk_master;
    logic sync_sel;
    logic port_en;
  } sst_ctrl_t;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[LAST-1:0], async_i};
  end

  // chain_q[LAST-1] is the synchronised copy, chain_q[LAST] its previous value
  assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];

  p_fall_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sst_regs.sv
module sst_regs
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              busy_i,
  output sst_ctrl_t         ctrl_o,
  output logic              run_o,
  output logic              hold_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  sst_ctrl_t ctrl_q;
  logic      ien_q;
  logic      flag_q;

  assign hold_wr_o = wr_i && (addr_i == A_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_CTRL) ctrl_q <= sst_ctrl_t'(wdata_i[7:0]);
      if (addr_i == A_IEN)  ien_q  <= wdata_i[0];
    end
  end

  // a new write wins over a hand-over in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (hold_wr_o) flag_q <= 1'b0;
    else if (load_i)    flag_q <= 1'b1;
  end

  assign run_o = ctrl_q.port_en & ctrl_q.sync_sel & ~ctrl_q.clk_master &
                 ctrl_q.tx_en & ~ctrl_q.rx_cont & ~ctrl_q.rx_single;
  assign ctrl_o = ctrl_q;
  assign irq_o  = flag_q & ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(ctrl_q);
      A_STAT:  rdata_o = DATA_W'({flag_q, ~busy_i});
      A_IEN:   rdata_o = DATA_W'(ien_q);
      default: rdata_o = '0;
    endcase
  end

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !hold_wr_o) |=> flag_q);
  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_wr_o |=> !flag_q);
endmodule

// File: rtl/sst_shift.sv
module sst_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fall_i,
  input  logic              hold_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frame9_i,
  input  logic              bit9_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int SH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_N = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LEN_X = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic              full_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              tx_q;
  logic [SH_W-1:0]   hold_ext;
  logic [CNT_W-1:0]  flen;
  logic              done;

  assign hold_ext = {frame9_i & bit9_i, hold_q};
  assign flen     = frame9_i ? LEN_X : LEN_N;
  assign done     = busy_q && fall_i && (cnt_q == flen);
  assign load_o   = run_i && full_q && (!busy_q || done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (hold_wr_i) begin
      hold_q <= wdata_i;
      full_q <= 1'b1;
    end else if (load_o) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b0;
    end else if (done) begin
      if (full_q) begin
        // back-to-back: next word's first bit on the same edge
        sh_q  <= hold_ext >> 1;
        tx_q  <= hold_ext[0];
        cnt_q <= CNT_W'(1);
      end else begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        tx_q   <= 1'b0;
      end
    end else if (busy_q && fall_i) begin
      tx_q  <= sh_q[0];
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (!busy_q && full_q) begin
      sh_q   <= hold_ext;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = tx_q;

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !busy_q);
  p_out_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fall_i) |=> $stable(tx_q));
  p_cnt_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LEN_X);
  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (cnt_q == '0 && !tx_q));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  output logic              sdo_o,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  sst_ctrl_t ctrl;
  logic      run, fall, hold_wr, load, busy;

  sst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sclk_i),
    .fall_o (fall)
  );

  sst_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .load_i   (load),
    .busy_i   (busy),
    .ctrl_o   (ctrl),
    .run_o    (run),
    .hold_wr_o(hold_wr),
    .rdata_o  (bus_rdata_o),
    .irq_o    (irq_o)
  );

  sst_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .fall_i   (fall),
    .hold_wr_i(hold_wr),
    .wdata_i  (bus_wdata_i),
    .frame9_i (ctrl.frame9),
    .bit9_i   (ctrl.bit9_val),
    .load_o   (load),
    .busy_o   (busy),
    .tx_o     (sdo_o)
  );
endmodule

// File: tb/tb_sync_slave_tx.sv
module tb_sync_slave_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk = 1'b1;
  logic       sdo;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdo_o(sdo),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic fall_cycle(output logic b);
    sclk = 1'b0;
    repeat (HALF_SCLK) @(negedge clk);
    b = sdo;
    sclk = 1'b1;
    repeat (HALF_SCLK) @(negedge clk);
  endtask

  task automatic shift_in(input int n, output logic [8:0] got);
    logic b;
    got = '0;
    for (int i = 0; i < n; i++) begin
      fall_cycle(b);
      got[i] = b;
    end
  endtask

  task automatic end_frame(input string req);
    logic b;
    logic [7:0] s;
    fall_cycle(b);
    rd_reg(2'd2, s);
    check(req, {15'd0, s[0]}, 16'd1);
    check(req, {15'd0, sdo}, 16'd0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(2'd0, d); check("R1 ctrl", {8'd0, d}, 16'h00);
    rd_reg(2'd2, d); check("R1 status", {8'd0, d}, 16'h01);
    rd_reg(2'd3, d); check("R1 ien", {8'd0, d}, 16'h00);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 sdo", {15'd0, sdo}, 16'd0);
  endtask

  task automatic t_gated(input logic [7:0] bad_ctrl, input logic [7:0] data);
    logic b;
    logic [7:0] s;
    logic [8:0] got;
    wr_reg(2'd0, bad_ctrl);
    wr_reg(2'd1, data);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      fall_cycle(b);
      check("R2 sdo idle", {15'd0, b}, 16'd0);
    end
    rd_reg(2'd2, s);
    check("R2 status", {8'd0, s}, 16'h01);
    wr_reg(2'd0, 8'h0B);
    repeat (2) @(negedge clk);
    shift_in(8, got);
    check("R2 R3 held word sent", {7'd0, got}, {8'd0, data});
    end_frame("R8 gated drain");
  endtask

  task automatic t_frame(input logic [7:0] c, input logic [7:0] data,
                         input int n, input logic [8:0] exp, input string req);
    logic [8:0] got;
    logic [7:0] s;
    wr_reg(2'd0, c);
    wr_reg(2'd1, data);
    repeat (2) @(negedge clk);
    rd_reg(2'd2, s);
    check("R8 busy", {15'd0, s[0]}, 16'd0);
    shift_in(n, got);
    check(req, {7'd0, got}, {7'd0, exp});
    end_frame("R8 empty after frame");
  endtask

  task automatic t_back2back;
    logic [7:0] s;
    logic [8:0] got;
    wr_reg(2'd0, 8'h0B);
    wr_reg(2'd1, 8'hC3);
    repeat (2) @(negedge clk);
    rd_reg(2'd2, s);
    check("R5 flag on first load", {15'd0, s[1]}, 16'd1);
    wr_reg(2'd1, 8'h69);
    rd_reg(2'd2, s);
    check("R6 flag clear on write", {15'd0, s[1]}, 16'd0);
    shift_in(8, got);
    check("R5 first word", {7'd0, got}, 16'h00C3);
    rd_reg(2'd2, s);
    check("R5 flag clear while waiting", {15'd0, s[1]}, 16'd0);
    check("R8 busy while waiting", {15'd0, s[0]}, 16'd0);
    shift_in(8, got);
    check("R5 second word", {7'd0, got}, 16'h0069);
    rd_reg(2'd2, s);
    check("R5 flag set on transfer", {15'd0, s[1]}, 16'd1);
    end_frame("R8 empty after pair");
  endtask

  task automatic t_irq;
    logic [8:0] got;
    wr_reg(2'd0, 8'h0B);
    wr_reg(2'd3, 8'h00);
    check("R7 masked", {15'd0, irq}, 16'd0);
    wr_reg(2'd3, 8'h01);
    check("R7 enabled", {15'd0, irq}, 16'd1);
    wr_reg(2'd1, 8'h5A);
    check("R7 R6 cleared by write", {15'd0, irq}, 16'd0);
    repeat (2) @(negedge clk);
    check("R7 set on load", {15'd0, irq}, 16'd1);
    shift_in(8, got);
    check("R3 irq word", {7'd0, got}, 16'h005A);
    end_frame("R8 irq drain");
    wr_reg(2'd3, 8'h00);
    check("R7 disabled", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_gated(8'h0F, 8'h96);  // internal-clock select set
    t_gated(8'h8B, 8'h3C);  // single-receive enable set
    t_gated(8'h4B, 8'hE1);  // continuous-receive enable set
    t_frame(8'h0B, 8'hB4, 8, 9'h0B4, "R3 lsb first 8-bit");
    t_frame(8'h3B, 8'hA5, 9, 9'h1A5, "R4 ninth bit one");
    t_frame(8'h1B, 8'hFF, 9, 9'h0FF, "R4 ninth bit zero");
    t_back2back();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule